// File: doc/BRIEF.md
# Bus Agent Reset Sequencer

This block sequences reset for a single agent on a shared system bus. It watches an asynchronous, active-low reset pin and an asynchronous init pin, and a power-good level that clears the block itself. Whenever the synchronized reset goes active, the block turns off the agent's bus output enable and issues a one-cycle strobe that tells both cache levels to drop their contents without write-back. It also times how long reset stays asserted, so that a release before the minimum hold time raises a violation flag.

When reset goes inactive, the block captures the configuration pins in that cycle. If the tristate option bit in that sample is set, the bus outputs stay disabled until the next reset. If that bit is clear and the init pin was seen active at the release, the block raises a self-test request and holds it until the test logic answers with a done pulse. In every case execution then begins with a one-cycle start pulse, and during that pulse the start address bus carries the fixed reset vector.

Top module: `agent_reset_seq`

## Requirements
- R1: Once the synchronized reset is active, `bus_oe` is low in the next cycle and stays low for as long as reset is held. Measured from the pin, `bus_oe` is low after at most three rising clock edges (two synchronizer stages and one register).
- R2: `inval_pulse` is high for exactly one cycle each time the synchronized reset becomes active. This includes the first cycle after `pwr_ok` rises.
- R3: `cfg_q` takes the value of `cfg_pins` in the cycle where the synchronized reset is first seen inactive, which is the third rising edge after the pin goes high. `cfg_q` does not change at any other time.
- R4: At each release, `hold_viol` is set if the reset pin was held low for fewer than `HOLD_CYC` clock cycles and cleared otherwise. It keeps that value until the next release.
- R5: When no self-test is requested, `start_pulse` is high for exactly one cycle, starting right after the release edge.
- R6: When `init_n` is low at release and `cfg_pins[TRI_BIT]` (bit 0 by default) is 0, `bist_req` goes high at the release edge and stays high until a cycle with `bist_done` high. That cycle is followed by a one-cycle `start_pulse` and `bist_req` dropping low. `bist_done` has no effect at any other time.
- R7: When `cfg_pins[TRI_BIT]` is 1 at release, `bus_oe` stays low until the next reset and no self-test is requested, even if init is active.
- R8: `start_addr` equals `RST_VEC` (default 36'hF_FFFF_FFF0) while `start_pulse` is high and is zero otherwise.
- R9: When the tristate bit is 0 at release, `bus_oe` is high from the release edge onward.
- R10: A reset that arrives while a self-test is pending clears `bist_req`, and no start pulse is issued for the aborted sequence.
- R11: While `pwr_ok` is low, all outputs are low and the reset pin is treated as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pwr_ok | input | 1 | Power good; low asynchronously clears the block |
| bus_rst_n | input | 1 | Asynchronous reset pin, active low |
| init_n | input | 1 | Asynchronous init pin, active low, sampled at release |
| cfg_pins | input | CFG_W | Configuration pins, sampled at release |
| bist_done | input | 1 | Self-test finished, one-cycle pulse |
| bus_oe | output | 1 | Bus output enable |
| inval_pulse | output | 1 | Cache invalidate strobe, no write-back |
| cfg_q | output | CFG_W | Latched power-on configuration |
| bist_req | output | 1 | Self-test request |
| hold_viol | output | 1 | Reset hold time was too short |
| start_pulse | output | 1 | Execution start strobe |
| start_addr | output | ADDR_W | Reset vector during start, zero otherwise |

## Verification
On every cycle, the assertions check the following:
- the output enable is off one cycle after the synchronized reset;
- the invalidate and start strobes last a single cycle;
- the address bus is tied to the start strobe;
- the configuration stays stable during reset;
- a self-test request never coexists with the tristate option.

Some behaviour can only be shown by the bench scenarios:
- the exact cycle of release relative to the pin;
- the hold-time boundary at `HOLD_CYC - 1` versus `HOLD_CYC`;
- which of the three release paths is taken for a given configuration and init sample;
- that a stray done pulse does nothing;
- that a reset during a pending self-test aborts the start.

// File: rtl/ars_pkg.sv
package ars_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_RESET = 2'd1,
        ST_BIST  = 2'd2
    } ars_state_e;

    localparam int unsigned DEF_ADDR_W = 36;
    localparam logic [DEF_ADDR_W-1:0] DEF_RST_VEC = 36'hF_FFFF_FFF0;
endpackage

// File: rtl/ars_sync.sv
module ars_sync #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s0_d, s0_q, s1_d, s1_q;

    always_comb begin
        s0_d = din;
        s1_d = s0_q;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s0_q <= RST_VAL;
            s1_q <= RST_VAL;
        end else begin
            s0_q <= s0_d;
            s1_q <= s1_d;
        end
    end

    assign dout = s1_q;
endmodule

// File: rtl/ars_hold_timer.sv
module ars_hold_timer #(
    parameter int unsigned HOLD_CYC = 100000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic inc,
    output logic met
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = CNT_W'(1);
        end else if (inc && cnt_q < LIMIT) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign met = (cnt_q >= LIMIT);
endmodule

// File: rtl/agent_reset_seq.sv
module agent_reset_seq
    import ars_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 100000,
    parameter int unsigned CFG_W    = 8,
    parameter int unsigned TRI_BIT  = 0,
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] RST_VEC = DEF_RST_VEC
) (
    input  logic              clk,
    input  logic              pwr_ok,
    input  logic              bus_rst_n,
    input  logic              init_n,
    input  logic [CFG_W-1:0]  cfg_pins,
    input  logic              bist_done,
    output logic              bus_oe,
    output logic              inval_pulse,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              bist_req,
    output logic              hold_viol,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int unsigned SYNC_W = 2;
    localparam int unsigned IDX_RST = 0;
    localparam int unsigned IDX_INIT = 1;

    typedef struct packed {
        ars_state_e       state;
        logic             oe;
        logic             inval;
        logic             start;
        logic             bist;
        logic             viol;
        logic [CFG_W-1:0] cfg;
    } seq_t;

    seq_t d, q;
    logic [SYNC_W-1:0] sync_out;
    logic rst_act, init_act, entry, hold_met, timer_inc;

    // Reset value marks reset active, init inactive
    ars_sync #(.W(SYNC_W), .RST_VAL(2'b01)) u_sync (
        .clk    (clk),
        .arst_n (pwr_ok),
        .din    ({~init_n, ~bus_rst_n}),
        .dout   (sync_out)
    );

    assign rst_act   = sync_out[IDX_RST];
    assign init_act  = sync_out[IDX_INIT];
    assign entry     = (q.state != ST_RESET) && rst_act;
    assign timer_inc = (q.state == ST_RESET) && rst_act;

    ars_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .arst_n (pwr_ok),
        .clr    (entry),
        .inc    (timer_inc),
        .met    (hold_met)
    );

    always_comb begin
        d       = q;
        d.inval = 1'b0;
        d.start = 1'b0;
        if (entry) begin
            d.state = ST_RESET;
            d.oe    = 1'b0;
            d.inval = 1'b1;
            d.bist  = 1'b0;
        end else begin
            unique case (q.state)
                ST_RESET: begin
                    if (!rst_act) begin
                        d.cfg  = cfg_pins;
                        d.viol = !hold_met;
                        d.oe   = !cfg_pins[TRI_BIT];
                        if (init_act && !cfg_pins[TRI_BIT]) begin
                            d.state = ST_BIST;
                            d.bist  = 1'b1;
                        end else begin
                            d.state = ST_RUN;
                            d.start = 1'b1;
                        end
                    end
                end
                ST_BIST: begin
                    if (bist_done) begin
                        d.state = ST_RUN;
                        d.bist  = 1'b0;
                        d.start = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            q <= '{state: ST_RUN, oe: 1'b0, inval: 1'b0, start: 1'b0,
                   bist: 1'b0, viol: 1'b0, cfg: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_oe      = q.oe;
    assign inval_pulse = q.inval;
    assign cfg_q       = q.cfg;
    assign bist_req    = q.bist;
    assign hold_viol   = q.viol;
    assign start_pulse = q.start;
    assign start_addr  = q.start ? RST_VEC : '0;
endmodule

// File: rtl/ars_checker.sv
module ars_checker #(
    parameter int unsigned CFG_W   = 8,
    parameter int unsigned TRI_BIT = 0,
    parameter int unsigned ADDR_W  = 36,
    parameter logic [ADDR_W-1:0] RST_VEC = '0
) (
    input logic              clk,
    input logic              pwr_ok,
    input logic              rst_act,
    input logic              bus_oe,
    input logic              inval_pulse,
    input logic [CFG_W-1:0]  cfg_q,
    input logic              bist_req,
    input logic              start_pulse,
    input logic [ADDR_W-1:0] start_addr
);
    a_r1_oe_off: assert property (@(posedge clk) disable iff (!pwr_ok)
        rst_act |=> !bus_oe);

    a_r2_inval_single: assert property (@(posedge clk) disable iff (!pwr_ok)
        inval_pulse |=> !inval_pulse);

    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!pwr_ok)
        rst_act |=> $stable(cfg_q));

    a_r5_start_single: assert property (@(posedge clk) disable iff (!pwr_ok)
        start_pulse |=> !start_pulse);

    a_r7_no_bist_tri: assert property (@(posedge clk) disable iff (!pwr_ok)
        bist_req |-> !cfg_q[TRI_BIT]);

    a_r8_vec: assert property (@(posedge clk) disable iff (!pwr_ok)
        start_pulse |-> start_addr == RST_VEC);

    a_r8_zero: assert property (@(posedge clk) disable iff (!pwr_ok)
        !start_pulse |-> start_addr == '0);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!pwr_ok)
        bist_req |-> !start_pulse);
endmodule

bind agent_reset_seq ars_checker #(
    .CFG_W(CFG_W), .TRI_BIT(TRI_BIT), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)
) u_ars_checker (
    .clk         (clk),
    .pwr_ok      (pwr_ok),
    .rst_act     (rst_act),
    .bus_oe      (bus_oe),
    .inval_pulse (inval_pulse),
    .cfg_q       (cfg_q),
    .bist_req    (bist_req),
    .start_pulse (start_pulse),
    .start_addr  (start_addr)
);

// File: tb/test_agent_reset_seq.sv
module test_agent_reset_seq;
    localparam int unsigned HOLD = 20;
    localparam int unsigned CW = 8;
    localparam int unsigned AW = 36;
    localparam logic [AW-1:0] VEC = 36'hF_FFFF_FFF0;

    logic clk = 1'b0;
    logic pwr_ok, bus_rst_n, init_n, bist_done;
    logic [CW-1:0] cfg_pins;
    logic bus_oe, inval_pulse, bist_req, hold_viol, start_pulse;
    logic [CW-1:0] cfg_q;
    logic [AW-1:0] start_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    agent_reset_seq #(.HOLD_CYC(HOLD), .CFG_W(CW), .TRI_BIT(0), .ADDR_W(AW), .RST_VEC(VEC))
    i_agent_reset_seq (
        .clk(clk), .pwr_ok(pwr_ok), .bus_rst_n(bus_rst_n), .init_n(init_n),
        .cfg_pins(cfg_pins), .bist_done(bist_done), .bus_oe(bus_oe),
        .inval_pulse(inval_pulse), .cfg_q(cfg_q), .bist_req(bist_req),
        .hold_viol(hold_viol), .start_pulse(start_pulse), .start_addr(start_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bist(input logic [CW-1:0] cfg, input bit init_on);
        return init_on && !cfg[0];
    endfunction

    function automatic bit exp_viol(input int len);
        return len < HOLD;
    endfunction

    // Reset pulse of len cycles (len >= 3), then release and check the start path
    task automatic do_reset(input int len, input logic [CW-1:0] cfg, input bit init_on,
                            input int dly, input bit finish_bist);
        bit eb;
        eb = exp_bist(cfg, init_on);
        @(negedge clk);
        bus_rst_n = 1'b0;
        init_n    = !init_on;
        cfg_pins  = cfg;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            chk(start_pulse == 1'b0, "R10 no start in reset", start_pulse, 0);
            if (k == 3) begin
                chk(bus_oe == 1'b0, "R1 oe off", bus_oe, 0);
                chk(inval_pulse == 1'b1, "R2 inval", inval_pulse, 1);
                chk(bist_req == 1'b0, "R10 bist cleared", bist_req, 0);
            end
            if (k == 4) chk(inval_pulse == 1'b0, "R2 inval one cycle", inval_pulse, 0);
            if (k > 3) chk(bus_oe == 1'b0, "R1 oe held off", bus_oe, 0);
        end
        bus_rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(start_pulse == 1'b0, "R5 not early", start_pulse, 0);
        @(negedge clk);
        chk(cfg_q == cfg, "R3 cfg capture", cfg_q, cfg);
        chk(hold_viol == exp_viol(len), "R4 hold flag", hold_viol, exp_viol(len));
        if (cfg[0]) chk(bus_oe == 1'b0, "R7 tristate kept", bus_oe, 0);
        else        chk(bus_oe == 1'b1, "R9 oe on", bus_oe, 1);
        chk(bist_req == eb, "R6 bist req", bist_req, eb);
        chk(start_pulse == !eb, "R5 start", start_pulse, !eb);
        if (!eb) begin
            chk(start_addr == VEC, "R8 vector", start_addr, VEC);
            @(negedge clk);
            chk(start_pulse == 1'b0, "R5 start one cycle", start_pulse, 0);
            chk(start_addr == '0, "R8 zero", start_addr, 0);
        end else if (finish_bist) begin
            for (int j = 0; j < dly; j++) begin
                @(negedge clk);
                chk(bist_req == 1'b1 && start_pulse == 1'b0, "R6 waiting", {bist_req, start_pulse}, 2'b10);
            end
            bist_done = 1'b1;
            @(negedge clk);
            bist_done = 1'b0;
            chk(start_pulse == 1'b1, "R6 start after done", start_pulse, 1);
            chk(bist_req == 1'b0, "R6 req dropped", bist_req, 0);
            chk(start_addr == VEC, "R8 vector after bist", start_addr, VEC);
            @(negedge clk);
            chk(start_pulse == 1'b0, "R6 start one cycle", start_pulse, 0);
        end
        init_n = 1'b1;
    endtask

    initial begin
        pwr_ok = 1'b0; bus_rst_n = 1'b0; init_n = 1'b1; bist_done = 1'b0; cfg_pins = '0;
        #23;
        chk(bus_oe == 0 && inval_pulse == 0 && start_pulse == 0 && bist_req == 0 && hold_viol == 0,
            "R11 cleared", {bus_oe, inval_pulse, start_pulse, bist_req, hold_viol}, 0);
        @(negedge clk);
        pwr_ok = 1'b1;
        @(negedge clk);
        chk(inval_pulse == 1'b1, "R2 power-up inval", inval_pulse, 1);
        chk(bus_oe == 1'b0, "R11 oe off at power-up", bus_oe, 0);
        repeat (HOLD + 4) @(negedge clk);
        bus_rst_n = 1'b1;
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 6 && !seen; i++) begin
                @(negedge clk);
                seen = start_pulse;
            end
            chk(seen, "R5 power-up start", seen, 1);
            chk(hold_viol == 1'b0, "R4 power-up hold ok", hold_viol, 0);
            chk(bus_oe == 1'b1, "R9 power-up oe", bus_oe, 1);
        end
        // Directed corners
        do_reset(HOLD - 1, 8'h00, 1'b0, 0, 1'b1);   // R4 short by one
        do_reset(HOLD,     8'h00, 1'b0, 0, 1'b1);   // R4 exact
        do_reset(HOLD + 2, 8'hA5, 1'b1, 0, 1'b1);   // R7 tristate overrides init
        do_reset(HOLD + 1, 8'h5A, 1'b1, 3, 1'b1);   // R6 self-test path
        // R6 stray done is ignored
        @(negedge clk);
        bist_done = 1'b1;
        @(negedge clk);
        bist_done = 1'b0;
        chk(start_pulse == 1'b0, "R6 stray done ignored", start_pulse, 0);
        // R10 abort a pending self-test
        do_reset(HOLD + 3, 8'h02, 1'b1, 0, 1'b0);
        do_reset(HOLD + 3, 8'h02, 1'b0, 0, 1'b1);
        // Random mix
        void'($urandom(32'h1234_5678));
        for (int n = 0; n < 14; n++) begin
            int len, dly;
            logic [CW-1:0] cfg;
            bit ini;
            len = 3 + int'($urandom_range(0, 2 * HOLD));
            dly = int'($urandom_range(0, 5));
            cfg = CW'($urandom);
            ini = 1'($urandom);
            do_reset(len, cfg, ini, dly, 1'b1);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule